// File: doc/BRIEF.md
# Prioritized Chip Select Decoder

This block is the address decoder of a processor bus with a 24-bit byte address. It holds four select channels. Each channel has a base page, a power-of-two block size, an access-direction qualifier and a data-width bit. On every bus access the block compares the address with all four channels. One cycle later it drives at most one active-low select line, chosen by fixed priority. Along with the select line it reports the data width of the selected channel.

The block watches for two configuration faults. The first is an address claimed by more than one channel at once. The second is a write into a range that is marked read-only. Each fault sets a sticky flag, and each can also raise a one-cycle bus error pulse if its enable bit is set.

The registers of the block live in a small window on the same bus. Accesses that fall into this window never drive a select line and never raise a bus error. A cold reset sets the boot layout, in which channel 0 covers the bottom of memory. A separate soft reset clears only the output stage and leaves the programmed configuration intact.

Top module: `csd_decoder`

## Requirements
- R1: After cold reset, channel 0 is valid, has read/write access and matches addresses 0x000000 to 0x001FFF only. Its register A reads 0x0001 (bit 0 is valid, bits 15:5 are address bits 23:13 of the base).
- R2: Channel 0's width bit (register B bit 6, also driven on `cs_wide`) takes the value of `width_pin` while cold reset is held. 0 means 8-bit and 1 means 16-bit.
- R3: After cold reset, channels 1 to 3 are invalid (register A reads 0x0000) and never drive their select lines.
- R4: A valid channel matches an address when the address bits 23:13, masked by the size code in register B bits 3:0, equal the base. The block spans 8 KB shifted left by the code (0 gives 8 KB, 11 or more gives 16 MB).
- R5: When several eligible channels match, only the one with the lowest index drives its line low. `cs_n` never has more than one bit low.
- R6: More than one eligible match sets the sticky conflict flag (control bit 0). A bus error is raised for it only when control bit 8 is set.
- R7: Register B bits 5:4 set the access qualifier: 00 read/write, 01 read-only, 10 write-only. A channel is eligible only for the directions it allows. A read-only and a write-only channel over the same range therefore never count as a conflict.
- R8: A write that hits a read-only channel and no eligible channel sets the sticky violation flag (control bit 1) and drives no select line. A bus error is raised for it only when control bit 9 is set.
- R9: Accesses to the register window (address bits 23:5 equal to those of `REG_BASE`) drive no select line, raise no bus error and set no flag, even where a channel covers them. Within the window, byte offset 0x00 is the control register, 0x08+4c is register A of channel c, and 0x0A+4c is register B of channel c.
- R10: Only cold reset clears the configuration and the flags. Soft reset clears only the output stage.
- R11: Select lines, width, bus error and read data are registered and valid the cycle after the access. The bus error lasts a single cycle. Writing 1 to a flag bit clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Cold reset, active low, synchronous |
| soft_rst_n | input | 1 | Soft reset of the output stage, active low |
| width_pin | input | 1 | Boot data width of channel 0, sampled during cold reset |
| bus_valid | input | 1 | A bus access is present this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 24 | Byte address of the access |
| bus_wdata | input | 16 | Write data for register window writes |
| cs_n | output | 4 | Active-low select lines, channel 0 in bit 0 |
| cs_wide | output | 1 | Width bit of the selected channel |
| bus_err | output | 1 | One-cycle bus error pulse |
| bus_rdata | output | 16 | Register read data |
| conflict_flag | output | 1 | Sticky overlap conflict flag |
| wpv_flag | output | 1 | Sticky write-protect violation flag |

## Verification
Every decode result (select lines, width, bus error and read data) is due exactly one clock edge after the access is presented. Flag and register updates are visible from that same edge onward. The bench drives each access on a falling edge, drops `bus_valid` on the next falling edge and samples all outputs there, which is half a cycle after the single register stage. The single-cycle length of the bus error is checked one further falling edge later, once no access is present.

// File: rtl/csd_pkg.sv
package csd_pkg;
  localparam int ADDR_W   = 24;
  localparam int PAGE_LSB = 13;
  localparam int BASE_W   = ADDR_W - PAGE_LSB;
  localparam int CODE_W   = 4;
  localparam int DATA_W   = 16;

  typedef enum logic [1:0] {
    ACC_RW  = 2'b00,
    ACC_RO  = 2'b01,
    ACC_WO  = 2'b10,
    ACC_RWX = 2'b11
  } acc_e;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [CODE_W-1:0] code;
    acc_e              acc;
    logic              wide;
    logic              valid;
  } chan_cfg_t;

  // register A layout: base in the top bits, valid in bit 0
  function automatic logic [DATA_W-1:0] pack_a(chan_cfg_t c);
    logic [DATA_W-1:0] v;
    v = '0;
    v[DATA_W-1 -: BASE_W] = c.base;
    v[0] = c.valid;
    return v;
  endfunction

  // register B layout: size code, access qualifier, width
  function automatic logic [DATA_W-1:0] pack_b(chan_cfg_t c);
    logic [DATA_W-1:0] v;
    v = '0;
    v[CODE_W-1:0] = c.code;
    v[CODE_W+1:CODE_W] = c.acc;
    v[CODE_W+2] = c.wide;
    return v;
  endfunction
endpackage

// File: rtl/csd_chan_match.sv
module csd_chan_match
  import csd_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int PLS = PAGE_LSB
) (
  input  chan_cfg_t       cfg,
  input  logic [AW-1:0]   addr,
  input  logic            wr,
  output logic            addr_hit,
  output logic            eligible,
  output logic            ro_block
);
  localparam int BW = AW - PLS;

  // mask keeps the page bits at or above the block size
  function automatic logic [BW-1:0] size_mask(logic [CODE_W-1:0] code);
    logic [BW-1:0] m;
    for (int i = 0; i < BW; i++) m[i] = (i >= int'(code));
    return m;
  endfunction

  logic [BW-1:0] diff;
  assign diff     = (addr[AW-1:PLS] ^ cfg.base) & size_mask(cfg.code);
  assign addr_hit = cfg.valid && (diff == '0);

  logic dir_ok;
  always_comb begin
    unique case (cfg.acc)
      ACC_RO:  dir_ok = !wr;
      ACC_WO:  dir_ok = wr;
      default: dir_ok = 1'b1;
    endcase
  end

  assign eligible = addr_hit && dir_ok;
  assign ro_block = addr_hit && wr && (cfg.acc == ACC_RO);

  always_comb begin
    a_r7_dir_gate: assert (!(eligible && wr && cfg.acc == ACC_RO));
  end
endmodule

// File: rtl/csd_prio_pick.sv
module csd_prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         multi
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_pick
    assign grant[i]  = req[i] && !seen[i];
    assign seen[i+1] = seen[i] || req[i];
  end

  function automatic int unsigned ones(logic [N-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < N; i++) n += int'(v[i]);
    return n;
  endfunction

  assign multi = ones(req) > 1;

  always_comb begin
    a_r5_single_grant: assert ($onehot0(grant));
    a_r5_grant_iff_req: assert ((grant != '0) == (req != '0));
  end
endmodule

// File: rtl/csd_regs.sv
module csd_regs
  import csd_pkg::*;
#(
  parameter int N     = 4,
  parameter int DW    = DATA_W,
  parameter int OFF_W = 4
) (
  input  logic             clk,
  input  logic             cold_rst_n,
  input  logic             width_pin,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] off,
  input  logic [DW-1:0]    wdata,
  input  logic             conf_set,
  input  logic             wpv_set,
  output chan_cfg_t [N-1:0] cfg,
  output logic             conf_en,
  output logic             wpv_en,
  output logic             stat_conf,
  output logic             stat_wpv,
  output logic [DW-1:0]    rdata
);
  localparam int CH_OFF   = 4;
  localparam int CTRL_OFF = 0;
  localparam int CONF_EN_BIT = 8;
  localparam int WPV_EN_BIT  = 9;

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (off == OFF_W'(CTRL_OFF));

  for (genvar c = 0; c < N; c++) begin : g_ch
    localparam logic [OFF_W-1:0] OFF_A = OFF_W'(CH_OFF + 2*c);
    localparam logic [OFF_W-1:0] OFF_B = OFF_W'(CH_OFF + 2*c + 1);
    logic wr_a, wr_b;
    assign wr_a = wr_en && (off == OFF_A);
    assign wr_b = wr_en && (off == OFF_B);

    always_ff @(posedge clk) begin
      if (!cold_rst_n) begin
        cfg[c].base  <= '0;
        cfg[c].code  <= '0;
        cfg[c].acc   <= ACC_RW;
        cfg[c].wide  <= (c == 0) ? width_pin : 1'b0;
        cfg[c].valid <= (c == 0);
      end else begin
        if (wr_a) begin
          cfg[c].base  <= wdata[DW-1 -: BASE_W];
          cfg[c].valid <= wdata[0];
        end
        if (wr_b) begin
          cfg[c].code <= wdata[CODE_W-1:0];
          cfg[c].acc  <= acc_e'(wdata[CODE_W+1:CODE_W]);
          cfg[c].wide <= wdata[CODE_W+2];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!cold_rst_n) begin
      conf_en   <= 1'b0;
      wpv_en    <= 1'b0;
      stat_conf <= 1'b0;
      stat_wpv  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        conf_en <= wdata[CONF_EN_BIT];
        wpv_en  <= wdata[WPV_EN_BIT];
      end
      if (conf_set)                stat_conf <= 1'b1;
      else if (ctrl_wr && wdata[0]) stat_conf <= 1'b0;
      if (wpv_set)                 stat_wpv <= 1'b1;
      else if (ctrl_wr && wdata[1]) stat_wpv <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (off == OFF_W'(CTRL_OFF)) begin
      rdata[0] = stat_conf;
      rdata[1] = stat_wpv;
      rdata[CONF_EN_BIT] = conf_en;
      rdata[WPV_EN_BIT]  = wpv_en;
    end
    for (int c = 0; c < N; c++) begin
      if (off == OFF_W'(CH_OFF + 2*c))     rdata = pack_a(cfg[c]);
      if (off == OFF_W'(CH_OFF + 2*c + 1)) rdata = pack_b(cfg[c]);
    end
  end

  a_r6_conf_sticky: assert property (@(posedge clk) disable iff (!cold_rst_n)
    conf_set |=> stat_conf);
  a_r8_wpv_sticky: assert property (@(posedge clk) disable iff (!cold_rst_n)
    wpv_set |=> stat_wpv);
  a_r11_flag_holds: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (stat_conf && !ctrl_wr) |=> stat_conf);
endmodule

// File: rtl/csd_decoder.sv
module csd_decoder
  import csd_pkg::*;
#(
  parameter int              AW       = ADDR_W,
  parameter int              NUM_CH   = 4,
  parameter int              DW       = DATA_W,
  parameter int              WIN_LSB  = 5,
  parameter logic [AW-1:0]   REG_BASE = 24'hFFF000
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              soft_rst_n,
  input  logic              width_pin,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [NUM_CH-1:0] cs_n,
  output logic              cs_wide,
  output logic              bus_err,
  output logic [DW-1:0]     bus_rdata,
  output logic              conflict_flag,
  output logic              wpv_flag
);
  localparam int OFF_W = WIN_LSB - 1;

  chan_cfg_t [NUM_CH-1:0] cfg;
  logic conf_en, wpv_en, stat_conf, stat_wpv;
  logic [DW-1:0] reg_rdata;

  // register window recognition
  logic in_win, win_access, dec_access;
  assign in_win     = bus_addr[AW-1:WIN_LSB] == REG_BASE[AW-1:WIN_LSB];
  assign win_access = bus_valid && in_win;
  assign dec_access = bus_valid && !in_win;

  // per-channel compare
  logic [NUM_CH-1:0] hit, elig, ro_hit;
  for (genvar c = 0; c < NUM_CH; c++) begin : g_match
    csd_chan_match #(.AW(AW), .PLS(PAGE_LSB)) u_match (
      .cfg      (cfg[c]),
      .addr     (bus_addr),
      .wr       (bus_write),
      .addr_hit (hit[c]),
      .eligible (elig[c]),
      .ro_block (ro_hit[c])
    );
  end

  logic [NUM_CH-1:0] grant;
  logic              multi;
  csd_prio_pick #(.N(NUM_CH)) u_pick (
    .req   (elig),
    .grant (grant),
    .multi (multi)
  );

  // named decode events
  logic conf_evt, wpv_evt, err_evt, sel_wide;
  assign conf_evt = dec_access && multi;
  assign wpv_evt  = dec_access && bus_write && (elig == '0) && (ro_hit != '0);
  assign err_evt  = (conf_evt && conf_en) || (wpv_evt && wpv_en);

  always_comb begin
    sel_wide = 1'b0;
    for (int c = 0; c < NUM_CH; c++)
      if (grant[c]) sel_wide = cfg[c].wide;
  end

  csd_regs #(.N(NUM_CH), .DW(DW), .OFF_W(OFF_W)) u_regs (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .width_pin  (width_pin),
    .wr_en      (win_access && bus_write),
    .off        (bus_addr[WIN_LSB-1:1]),
    .wdata      (bus_wdata),
    .conf_set   (conf_evt),
    .wpv_set    (wpv_evt),
    .cfg        (cfg),
    .conf_en    (conf_en),
    .wpv_en     (wpv_en),
    .stat_conf  (stat_conf),
    .stat_wpv   (stat_wpv),
    .rdata      (reg_rdata)
  );

  // output stage
  always_ff @(posedge clk) begin
    if (!cold_rst_n || !soft_rst_n) begin
      cs_n      <= '1;
      cs_wide   <= 1'b0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      cs_n      <= dec_access ? ~grant : '1;
      cs_wide   <= dec_access && sel_wide;
      bus_err   <= err_evt;
      bus_rdata <= (win_access && !bus_write) ? reg_rdata : '0;
    end
  end

  assign conflict_flag = stat_conf;
  assign wpv_flag      = stat_wpv;

  a_r5_onehot_select: assert property (@(posedge clk) disable iff (!cold_rst_n)
    $onehot0(~cs_n));
  a_r9_window_quiet: assert property (@(posedge clk) disable iff (!cold_rst_n)
    win_access |=> ((&cs_n) && !bus_err));
  a_r8_wpv_no_select: assert property (@(posedge clk) disable iff (!cold_rst_n)
    wpv_evt |=> (&cs_n));
  a_r6_conf_flag: assert property (@(posedge clk) disable iff (!cold_rst_n)
    conf_evt |=> conflict_flag);
  a_r11_err_pulse: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !bus_valid |=> !bus_err);
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !bus_valid |=> (&cs_n));
endmodule

// File: tb/csd_decoder_bench.sv
module csd_decoder_bench;
  localparam logic [23:0] RB = 24'hFFF000;

  logic        clk = 1'b0;
  logic        cold_rst_n = 1'b0, soft_rst_n = 1'b1, width_pin = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [3:0]  cs_n;
  logic        cs_wide, bus_err, conflict_flag, wpv_flag;
  logic [15:0] bus_rdata;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  csd_decoder u_csd_decoder (
    .clk(clk), .cold_rst_n(cold_rst_n), .soft_rst_n(soft_rst_n), .width_pin(width_pin),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cs_n(cs_n), .cs_wide(cs_wide), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .conflict_flag(conflict_flag), .wpv_flag(wpv_flag)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one access; outputs sampled at the falling edge after the registering edge
  task automatic access(logic [23:0] a, logic w, logic [15:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic wreg(logic [7:0] off, logic [15:0] d);
    access(RB + 24'(off), 1'b1, d);
  endtask

  task automatic rreg(logic [7:0] off, output logic [15:0] d);
    access(RB + 24'(off), 1'b0, '0);
    d = bus_rdata;
  endtask

  // restated match rule using byte ranges
  function automatic bit in_block(logic [23:0] a, logic [23:0] base, int code);
    int unsigned sz;
    sz = 32'd8192 << ((code > 11) ? 11 : code);
    return (int'(a) / sz) == (int'(base) / sz);
  endfunction

  task automatic cold_reset(logic pin);
    @(negedge clk);
    cold_rst_n = 1'b0; width_pin = pin;
    repeat (3) @(negedge clk);
    cold_rst_n = 1'b1;
  endtask

  task automatic t_boot;
    logic [15:0] d;
    cold_reset(1'b1);
    chk("R11 reset cs_n", cs_n, 4'hF);
    chk("R11 reset err", bus_err, 0);
    rreg(8'h08, d); chk("R1 ch0 A", d, 16'h0001);
    rreg(8'h0A, d); chk("R2 ch0 B wide", d, 16'h0040);
    rreg(8'h0C, d); chk("R3 ch1 A", d, 16'h0000);
    access(24'h001FFE, 1'b0, '0);
    chk("R1 top of boot block", cs_n, 4'hE);
    chk("R2 cs_wide", cs_wide, 1);
    access(24'h002000, 1'b0, '0);
    chk("R1 R3 above boot block", cs_n, 4'hF);
    cold_reset(1'b0);
    access(24'h000000, 1'b1, '0);
    chk("R2 narrow cs", cs_n, 4'hE);
    chk("R2 narrow width", cs_wide, 0);
  endtask

  task automatic t_match;
    wreg(8'h0C, 16'h1001); wreg(8'h0E, 16'h0003);
    access(24'h10FFFE, 1'b0, '0);
    chk("R4 inside 64K", cs_n, in_block(24'h10FFFE, 24'h100000, 3) ? 4'hD : 4'hF);
    access(24'h110000, 1'b1, '0);
    chk("R4 outside 64K", cs_n, in_block(24'h110000, 24'h100000, 3) ? 4'hD : 4'hF);
  endtask

  task automatic t_prio;
    logic [15:0] d;
    wreg(8'h10, 16'h1001); wreg(8'h12, 16'h0007);
    access(24'h100010, 1'b0, '0);
    chk("R5 low index wins", cs_n, 4'hD);
    chk("R6 no err when disabled", bus_err, 0);
    chk("R6 conflict flag", conflict_flag, 1);
    access(24'h180000, 1'b0, '0);
    chk("R4 1M block only ch2", cs_n, 4'hB);
    wreg(8'h00, 16'h0100);
    access(24'h100010, 1'b0, '0);
    chk("R6 err enabled", bus_err, 1);
    @(negedge clk);
    chk("R11 err single cycle", bus_err, 0);
    wreg(8'h00, 16'h0101);
    rreg(8'h00, d);
    chk("R11 W1C conflict", d, 16'h0100);
  endtask

  task automatic t_dir;
    logic [15:0] d;
    wreg(8'h10, 16'h4001); wreg(8'h12, 16'h0020);
    wreg(8'h14, 16'h4001); wreg(8'h16, 16'h0010);
    wreg(8'h00, 16'h0300);
    access(24'h400100, 1'b0, '0);
    chk("R7 read to RO ch3", cs_n, 4'h7);
    access(24'h400100, 1'b1, '0);
    chk("R7 write to WO ch2", cs_n, 4'hB);
    chk("R7 no err", bus_err, 0);
    rreg(8'h00, d);
    chk("R7 no conflict no wpv", d, 16'h0300);
    wreg(8'h10, 16'h4000);
    access(24'h400100, 1'b1, '0);
    chk("R8 blocked write", cs_n, 4'hF);
    chk("R8 err", bus_err, 1);
    chk("R8 wpv flag", wpv_flag, 1);
    wreg(8'h00, 16'h0002);
    access(24'h400100, 1'b1, '0);
    chk("R8 err masked", bus_err, 0);
    chk("R8 flag set again", wpv_flag, 1);
    wreg(8'h00, 16'h0102);
    chk("R11 W1C wpv", wpv_flag, 0);
  endtask

  task automatic t_window;
    logic [15:0] d;
    wreg(8'h0A, 16'h000B);
    wreg(8'h0E, 16'h000B);
    access(RB + 24'h2, 1'b0, '0);
    chk("R9 window read cs", cs_n, 4'hF);
    chk("R9 window read err", bus_err, 0);
    access(RB + 24'hE, 1'b1, 16'h000B);
    chk("R9 config write err", bus_err, 0);
    chk("R9 config write cs", cs_n, 4'hF);
    chk("R9 no flag", conflict_flag, 0);
    access(24'h000100, 1'b0, '0);
    chk("R5 overlap picks ch0", cs_n, 4'hE);
    chk("R6 overlap err", bus_err, 1);
    soft_rst_n = 1'b0;
    @(negedge clk);
    chk("R10 soft reset output", bus_err, 0);
    soft_rst_n = 1'b1;
    rreg(8'h0E, d); chk("R10 ch1 kept", d, 16'h000B);
    chk("R10 flag kept", conflict_flag, 1);
    cold_reset(1'b0);
    rreg(8'h0C, d); chk("R10 cold clears ch1", d, 16'h0000);
    chk("R10 cold clears flag", conflict_flag, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_boot();
    t_match();
    t_prio();
    t_dir();
    t_window();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule